// File: doc/BRIEF.md
# Load-Use and Shared-Port Stall Controller

This block is the hazard detector of a five-stage in-order pipeline. Each cycle it looks at the source register fields of the instruction in decode, at whether the instruction in execute is a load and which register it writes, and at whether the instruction in the memory stage is using the data port. From these it decides whether the program counter and the fetch/decode register may advance, whether a no-op must be injected into the decode/execute register, and whether a no-op must take the place of the instruction fetch.

Two hazards are handled. A load whose result is needed by the very next instruction as an execute-stage operand holds fetch and decode for one cycle while a no-op moves on into execute; later consumers are covered by forwarding and never stall. When a configuration input declares that instructions and data share one memory port, a data access in the memory stage blocks the fetch of that cycle, so the PC holds and a no-op is written into the fetch/decode register while older instructions keep moving. Reads all happen in decode and writes all happen in write-back, so no write-after-read or write-after-write check exists.

The outputs are combinational. A small state machine remembers what was done in the previous cycle so that one load-use occurrence never holds the pipeline for two cycles. States: `ST_RUN` (no stall last cycle), `ST_LU_HOLD` (load-use stall last cycle), `ST_IF_HOLD` (fetch stall last cycle). Transitions each cycle: to `ST_LU_HOLD` when a load-use stall is issued, else to `ST_IF_HOLD` when a fetch stall is issued, else to `ST_RUN`; reset enters `ST_RUN`.

Top module: `hazard_stall_ctrl`

## Requirements
- R1: When `ex_load` is 1, `ex_dst` is nonzero, `dec_src_a_used` is 1 and `dec_src_a` equals `ex_dst`, the outputs are `pc_en`=0, `fd_en`=0, `dx_nop`=1, `fd_nop`=0 (unless R10 applies).
- R2: The same stall as R1 occurs when the match is on `dec_src_b` with `dec_src_b_used`=1 and `dec_is_store`=0.
- R3: When `ex_load` is 0, or no used source matches `ex_dst`, no load-use stall occurs (`dx_nop`=0), so a consumer two or more instructions behind a load never stalls.
- R4: With `dec_is_store`=1, a match on `dec_src_b` (the store data) causes no stall, while a match on `dec_src_a` (the base address) still stalls as in R1.
- R5: A load whose `ex_dst` is 0 never causes a stall.
- R6: A source whose used flag is 0 never causes a stall, whatever its value.
- R7: When `cfg_shared_port` is 1 and `mem_data_access` is 1 and no load-use stall is issued, the outputs are `pc_en`=0, `fd_en`=1, `fd_nop`=1, `dx_nop`=0.
- R8: When `cfg_shared_port` is 0, `mem_data_access` has no effect on any output.
- R9: When a load-use stall and a port conflict occur together, the load-use stall wins: `pc_en`=0, `fd_en`=0, `dx_nop`=1, `fd_nop`=0.
- R10: In the cycle right after a load-use stall, no load-use stall is issued even if the inputs still show the hazard; a fetch stall may still be issued there. Two cycles later it can stall again.
- R11: After reset, with no hazard on the inputs, `pc_en`=1, `fd_en`=1, `dx_nop`=0, `fd_nop`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_shared_port | input | 1 | 1 when fetch and data share one memory port |
| dec_src_a | input | REG_AW | Decode-stage first source (base address for stores) |
| dec_src_a_used | input | 1 | Decode instruction reads `dec_src_a` |
| dec_src_b | input | REG_AW | Decode-stage second source (data for stores) |
| dec_src_b_used | input | 1 | Decode instruction reads `dec_src_b` |
| dec_is_store | input | 1 | Decode instruction is a store |
| ex_load | input | 1 | Execute-stage instruction is a load |
| ex_dst | input | REG_AW | Execute-stage destination register |
| mem_data_access | input | 1 | Memory-stage instruction reads or writes data memory |
| pc_en | output | 1 | PC may update |
| fd_en | output | 1 | Fetch/decode register may load |
| dx_nop | output | 1 | Clear control of decode/execute register (bubble) |
| fd_nop | output | 1 | Load a no-op into fetch/decode instead of the fetched word |

## Verification
The hardest situation to reach is a load-use hazard whose inputs persist into the following cycle, since a real pipeline never presents it; the bench drives the same hazard for three cycles in a row and expects stall, pass, stall. It also drives a port conflict in the cycle after a load-use stall and the coincidence of both hazards, and then runs a long stretch of random stimulus over a four-register space so that matches, register 0 and store exemptions occur often, comparing every cycle against a behavioural model.

// File: rtl/hz_pkg.sv
package hz_pkg;
    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_LU_HOLD = 2'd1,
        ST_IF_HOLD = 2'd2
    } hz_state_e;
endpackage

// File: rtl/hz_src_match.sv
module hz_src_match #(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src,
    input  logic              src_used,
    input  logic              src_exempt,
    input  logic [REG_AW-1:0] dst,
    output logic              hit
);
    // register 0 is hard-wired, a write to it never creates a dependence
    always_comb begin
        hit = src_used && !src_exempt && (dst != '0) && (src == dst);
    end
endmodule

// File: rtl/hz_loaduse.sv
module hz_loaduse #(
    parameter int REG_AW = 5,
    parameter int NSRC   = 2
) (
    input  logic [NSRC-1:0][REG_AW-1:0] srcs,
    input  logic [NSRC-1:0]             used,
    input  logic [NSRC-1:0]             exempt,
    input  logic                        ex_load,
    input  logic [REG_AW-1:0]           ex_dst,
    output logic                        raw_hit
);
    logic [NSRC-1:0] hits;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        hz_src_match #(.REG_AW(REG_AW)) match_i (
            .src       (srcs[g]),
            .src_used  (used[g]),
            .src_exempt(exempt[g]),
            .dst       (ex_dst),
            .hit       (hits[g])
        );
    end

    always_comb begin
        raw_hit = ex_load && (|hits);
    end
endmodule

// File: rtl/hz_port_conflict.sv
module hz_port_conflict (
    input  logic cfg_shared_port,
    input  logic mem_data_access,
    output logic conflict
);
    always_comb begin
        conflict = cfg_shared_port && mem_data_access;
    end
endmodule

// File: rtl/hazard_stall_ctrl.sv
module hazard_stall_ctrl
    import hz_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_shared_port,
    input  logic [REG_AW-1:0] dec_src_a,
    input  logic              dec_src_a_used,
    input  logic [REG_AW-1:0] dec_src_b,
    input  logic              dec_src_b_used,
    input  logic              dec_is_store,
    input  logic              ex_load,
    input  logic [REG_AW-1:0] ex_dst,
    input  logic              mem_data_access,
    output logic              pc_en,
    output logic              fd_en,
    output logic              dx_nop,
    output logic              fd_nop
);
    localparam int NSRC = 2;

    hz_state_e state_q, state_d;
    logic      raw_hit, conflict, lu_allowed, lu_stall, if_stall;

    hz_loaduse #(.REG_AW(REG_AW), .NSRC(NSRC)) loaduse_i (
        .srcs   ({dec_src_b, dec_src_a}),
        .used   ({dec_src_b_used, dec_src_a_used}),
        .exempt ({dec_is_store, 1'b0}),
        .ex_load(ex_load),
        .ex_dst (ex_dst),
        .raw_hit(raw_hit)
    );

    hz_port_conflict port_i (
        .cfg_shared_port(cfg_shared_port),
        .mem_data_access(mem_data_access),
        .conflict       (conflict)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        lu_allowed = 1'b1;
        unique case (state_q)
            ST_RUN:     lu_allowed = 1'b1;
            ST_LU_HOLD: lu_allowed = 1'b0;
            ST_IF_HOLD: lu_allowed = 1'b1;
            default:    lu_allowed = 1'b1;
        endcase
        lu_stall = raw_hit && lu_allowed;
        if_stall = conflict && !lu_stall;

        if (lu_stall)      state_d = ST_LU_HOLD;
        else if (if_stall) state_d = ST_IF_HOLD;
        else               state_d = ST_RUN;
    end

    always_comb begin
        pc_en  = 1'b1;
        fd_en  = 1'b1;
        dx_nop = 1'b0;
        fd_nop = 1'b0;
        if (lu_stall) begin
            pc_en  = 1'b0;
            fd_en  = 1'b0;
            dx_nop = 1'b1;
        end else if (if_stall) begin
            pc_en  = 1'b0;
            fd_nop = 1'b1;
        end
    end

    assert_lu_holds_front_R1: assert property (@(posedge clk) disable iff (!rst_n)
        dx_nop |-> (!pc_en && !fd_en && !fd_nop));

    assert_single_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dx_nop |=> !dx_nop);

    assert_zero_dest_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_dst == '0) |-> !dx_nop);

    assert_no_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_load |-> !dx_nop);

    assert_fetch_bubble_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fd_nop |-> (!pc_en && fd_en && !dx_nop));

    assert_private_port_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_shared_port |-> !fd_nop);

    assert_one_bubble_kind_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(dx_nop && fd_nop));
endmodule

// File: tb/hazard_stall_ctrl_tb_top.sv
module hazard_stall_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_shared_port = 1'b0;
    logic [AW-1:0] dec_src_a = '0, dec_src_b = '0, ex_dst = '0;
    logic dec_src_a_used = 1'b0, dec_src_b_used = 1'b0, dec_is_store = 1'b0;
    logic ex_load = 1'b0, mem_data_access = 1'b0;
    logic pc_en, fd_en, dx_nop, fd_nop;

    int total = 0;
    int bad = 0;
    bit model_prev_lu = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hazard_stall_ctrl #(.REG_AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_shared_port(cfg_shared_port),
        .dec_src_a(dec_src_a), .dec_src_a_used(dec_src_a_used),
        .dec_src_b(dec_src_b), .dec_src_b_used(dec_src_b_used),
        .dec_is_store(dec_is_store), .ex_load(ex_load), .ex_dst(ex_dst),
        .mem_data_access(mem_data_access),
        .pc_en(pc_en), .fd_en(fd_en), .dx_nop(dx_nop), .fd_nop(fd_nop)
    );

    // behavioural reference: returns {pc_en, fd_en, dx_nop, fd_nop}
    function automatic logic [3:0] model_out(output bit lu);
        bit dep = 0;
        if (ex_load && ex_dst != 0) begin
            if (dec_src_a_used && dec_src_a == ex_dst) dep = 1;
            if (dec_src_b_used && !dec_is_store && dec_src_b == ex_dst) dep = 1;
        end
        lu = dep && !model_prev_lu;
        if (lu) return 4'b0010;
        if (cfg_shared_port && mem_data_access) return 4'b0101;
        return 4'b1100;
    endfunction

    task automatic drive(input bit sh, input bit ld, input int dst,
                         input int a, input bit au, input int b, input bit bu,
                         input bit st, input bit acc);
        cfg_shared_port = sh; ex_load = ld; ex_dst = AW'(dst);
        dec_src_a = AW'(a); dec_src_a_used = au;
        dec_src_b = AW'(b); dec_src_b_used = bu;
        dec_is_store = st; mem_data_access = acc;
    endtask

    // inputs set just after a rising edge; compare at the falling edge; model state moves at the next rising edge
    task automatic step(input string req);
        bit lu;
        logic [3:0] exp, act;
        @(negedge clk);
        exp = model_out(lu);
        act = {pc_en, fd_en, dx_nop, fd_nop};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got pc/fd/dxnop/fdnop=%b expected %b", req, act, exp);
        end
        @(posedge clk);
        model_prev_lu = rst_n ? lu : 0;
        #1;
    endtask

    initial begin
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        step("R11");                                  // idle after reset
        drive(0, 1, 3, 3, 1, 0, 0, 0, 0); step("R1"); // src a match
        drive(0, 0, 0, 3, 1, 0, 0, 0, 0); step("R3"); // bubble in ex
        drive(0, 1, 7, 0, 0, 7, 1, 0, 0); step("R2"); // src b match
        drive(0, 0, 0, 0, 0, 7, 1, 0, 0); step("R3");
        drive(0, 1, 4, 1, 1, 2, 1, 0, 0); step("R3"); // load, no match
        drive(0, 1, 9, 2, 1, 9, 1, 1, 0); step("R4"); // store data only
        drive(0, 1, 9, 9, 1, 5, 1, 1, 0); step("R4"); // store base
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0); step("R3");
        drive(0, 1, 0, 0, 1, 0, 1, 0, 0); step("R5"); // dest reg 0
        drive(0, 1, 6, 6, 0, 6, 0, 0, 0); step("R6"); // unused sources
        drive(1, 0, 0, 0, 0, 0, 0, 0, 1); step("R7");
        drive(1, 0, 0, 0, 0, 0, 0, 1, 1); step("R7"); // back-to-back access
        drive(0, 0, 0, 0, 0, 0, 0, 0, 1); step("R8");
        drive(0, 1, 2, 5, 1, 1, 1, 0, 1); step("R8");
        drive(1, 1, 8, 8, 1, 0, 0, 0, 1); step("R9"); // both
        drive(1, 1, 8, 8, 1, 0, 0, 0, 1); step("R10"); // suppressed, fetch stall
        drive(0, 1, 8, 8, 1, 0, 0, 0, 0); step("R10"); // stalls again
        drive(0, 1, 8, 8, 1, 0, 0, 0, 0); step("R10");
        drive(0, 1, 8, 8, 1, 0, 0, 0, 0); step("R10");
        rst_n = 1'b0; drive(0, 1, 8, 8, 1, 0, 0, 0, 0);
        @(posedge clk); #1 rst_n = 1'b1; model_prev_lu = 0;
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0); step("R11");
        for (int i = 0; i < 2000; i++) begin
            drive($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 3),
                  $urandom_range(0, 3), $urandom_range(0, 1),
                  $urandom_range(0, 3), $urandom_range(0, 1),
                  $urandom_range(0, 1), $urandom_range(0, 1));
            step("R3");
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule